// File: doc/BRIEF.md
# Write-Once Snooping Cache Controller

This block is the cache controller that sits between one processor and a shared bus in a multiprocessor. It holds a small direct-mapped array of single-word lines. Each line is Invalid, Clean or Dirty. The CPU side serves one read or write at a time. The bus side issues reads, invalidating writes and writebacks. The snoop side watches the transactions that other caches place on the bus and reacts to them.

The write-once behaviour works as follows. The first write to a shared word goes out on the bus so that every other copy is dropped, and the word then becomes Dirty. Later writes to that Dirty word stay inside the cache. Another processor may then read or write a word that this cache holds Dirty. In that case the controller raises a memory-inhibit line and drives the current value itself, so main memory stays quiet.

Bus arbitration and main memory sit outside this block. A grant input marks the cycle in which the controller's bus transaction happens. In that same cycle the bus returns read data from memory or from another cache. The system never grants this cache during a cycle in which it is snooping another cache's transaction.

Top module: `wo_snoop_cache`

## Requirements
- R1: After reset every line is Invalid, and cpu_ready, bus_req and snp_inhibit are low.
- R2: A read whose address hits a Clean or Dirty line raises cpu_ready in the same cycle as the request, with the stored word on cpu_rdata and bus_req low.
- R3: A read miss raises bus_req with bus_cmd 0 (read) and the requested address. It completes in the grant cycle with bus_rdata returned on cpu_rdata, and the line is installed Clean.
- R4: A write to a Clean line, or a write miss, raises bus_req with bus_cmd 1 (invalidating write), the address and the write data. It completes in the grant cycle, and the line becomes Dirty with the written word.
- R5: A write that hits a Dirty line completes in the request cycle with no bus request, and updates the stored word.
- R6: When a snooped access (snp_valid, snp_wr 1 for a write, 0 for a read) hits a Dirty line, snp_inhibit is high and snp_data carries the stored word in that same cycle. Afterwards the line is Clean for a snooped read and Invalid for a snooped write.
- R7: A snooped write that hits a Clean line makes it Invalid without inhibit. A snooped read of a Clean line changes nothing.
- R8: A miss whose index holds a Dirty line with another tag first issues a writeback (bus_cmd 2) with the victim's address and word, and then the read or write of R3 or R4. If a snoop removes the victim's Dirty state while the writeback waits, the writeback is skipped.
- R9: In a cycle with snp_valid high, a local request is not served and cpu_ready stays low.
- R10: Only one local request is outstanding. bus_req stays high until granted unless a snoop cancels a pending writeback, and cpu_ready stays low while the transaction is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU request, held stable until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address (low IW bits index the array) |
| cpu_wdata | input | DW | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DW | Read data, valid with cpu_ready on a read |
| bus_req | output | 1 | Bus transaction wanted |
| bus_cmd | output | 2 | 0 read, 1 invalidating write, 2 writeback |
| bus_addr | output | AW | Bus transaction address |
| bus_wdata | output | DW | Data for write or writeback |
| bus_gnt | input | 1 | Transaction happens this cycle |
| bus_rdata | input | DW | Read data in the grant cycle |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_wr | input | 1 | Snooped transaction is a write |
| snp_addr | input | AW | Snooped address |
| snp_inhibit | output | 1 | Memory must not answer; this cache supplies data |
| snp_data | output | DW | Supplied word when snp_inhibit is high |

## Verification
Hits, snoop responses and the inhibit line are combinational, so they are due in the cycle the stimulus is applied. Bus-served requests are due in the grant cycle. A line's state change shows up from the next cycle on. The bench drives inputs just after each rising edge. At every falling edge it compares all outputs with a behavioural model of the line states, the pending phase and memory, and it updates that model for the coming edge. This keeps each comparison in the cycle its result is due. Grant delays are randomized and can be held off, so pending-request, stall and cancelled-writeback cycles all get exercised.

// File: rtl/wo_cache_pkg.sv
package wo_cache_pkg;
  typedef enum logic [1:0] {
    LS_INV   = 2'd0,
    LS_CLEAN = 2'd1,
    LS_DIRTY = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    BC_RD = 2'd0,
    BC_WR = 2'd1,
    BC_WB = 2'd2
  } bus_cmd_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WB   = 2'd1,
    PH_FILL = 2'd2,
    PH_WR   = 2'd3
  } phase_e;
endpackage

// File: rtl/wo_line_store.sv
module wo_line_store
  import wo_cache_pkg::*;
#(
  parameter int IW = 3,
  parameter int TW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] la_idx,
  output line_st_e      la_st,
  output logic [TW-1:0] la_tag,
  output logic [DW-1:0] la_data,
  input  logic [IW-1:0] sa_idx,
  output line_st_e      sa_st,
  output logic [TW-1:0] sa_tag,
  output logic [DW-1:0] sa_data,
  input  logic          sw_en,
  input  line_st_e      sw_st,
  input  logic          lw_en,
  input  line_st_e      lw_st,
  input  logic [TW-1:0] lw_tag,
  input  logic [DW-1:0] lw_data
);
  localparam int NL = 1 << IW;

  line_st_e      st_w  [NL];
  logic [TW-1:0] tag_w [NL];
  logic [DW-1:0] dat_w [NL];

  for (genvar g = 0; g < NL; g++) begin : g_line
    line_st_e      st_q;
    logic [TW-1:0] tag_q;
    logic [DW-1:0] dat_q;
    logic          l_sel;
    logic          s_sel;

    assign l_sel = lw_en && (la_idx == IW'(g));
    assign s_sel = sw_en && (sa_idx == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q <= LS_INV;
      end else if (l_sel) begin
        st_q <= lw_st;
      end else if (s_sel) begin
        st_q <= sw_st;
      end
    end

    always_ff @(posedge clk) begin
      if (l_sel) begin
        tag_q <= lw_tag;
        dat_q <= lw_data;
      end
    end

    assign st_w[g]  = st_q;
    assign tag_w[g] = tag_q;
    assign dat_w[g] = dat_q;
  end

  assign la_st   = st_w[la_idx];
  assign la_tag  = tag_w[la_idx];
  assign la_data = dat_w[la_idx];
  assign sa_st   = st_w[sa_idx];
  assign sa_tag  = tag_w[sa_idx];
  assign sa_data = dat_w[sa_idx];
endmodule

// File: rtl/wo_snoop_unit.sv
module wo_snoop_unit
  import wo_cache_pkg::*;
#(
  parameter int TW = 5,
  parameter int DW = 16
) (
  input  logic          snp_valid,
  input  logic          snp_wr,
  input  logic [TW-1:0] snp_tag,
  input  line_st_e      sa_st,
  input  logic [TW-1:0] sa_tag,
  input  logic [DW-1:0] sa_data,
  output logic          inhibit,
  output logic [DW-1:0] sdata,
  output logic          sw_en,
  output line_st_e      sw_st
);
  logic s_hit;

  always_comb begin
    s_hit   = snp_valid && (sa_st != LS_INV) && (sa_tag == snp_tag);
    inhibit = s_hit && (sa_st == LS_DIRTY);
    sdata   = inhibit ? sa_data : '0;
    // an owner that supplied data keeps a Clean copy on a read, drops it on a write
    sw_en   = s_hit && (snp_wr || (sa_st == LS_DIRTY));
    sw_st   = snp_wr ? LS_INV : LS_CLEAN;
  end
endmodule

// File: rtl/wo_ctrl_fsm.sv
module wo_ctrl_fsm
  import wo_cache_pkg::*;
#(
  parameter int IW = 3,
  parameter int TW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [TW-1:0] cpu_tag,
  input  logic [IW-1:0] cpu_idx,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          snp_valid,
  input  line_st_e      la_st,
  input  logic [TW-1:0] la_tag,
  input  logic [DW-1:0] la_data,
  input  logic          bus_gnt,
  input  logic [DW-1:0] bus_rdata,
  output logic          cpu_ready,
  output logic [DW-1:0] cpu_rdata,
  output logic          bus_req,
  output bus_cmd_e      bus_cmd,
  output logic [TW+IW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          lw_en,
  output line_st_e      lw_st,
  output logic [TW-1:0] lw_tag,
  output logic [DW-1:0] lw_data
);
  phase_e phase_q, phase_d;
  logic   hit, victim_dirty;
  phase_e after_wb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  always_comb begin
    hit          = (la_st != LS_INV) && (la_tag == cpu_tag);
    victim_dirty = (la_st == LS_DIRTY) && !hit;
    after_wb     = cpu_we ? PH_WR : PH_FILL;
    phase_d      = phase_q;
    cpu_ready    = 1'b0;
    cpu_rdata    = '0;
    bus_req      = 1'b0;
    bus_cmd      = BC_RD;
    bus_addr     = {cpu_tag, cpu_idx};
    bus_wdata    = cpu_wdata;
    lw_en        = 1'b0;
    lw_st        = LS_INV;
    lw_tag       = cpu_tag;
    lw_data      = cpu_wdata;
    unique case (phase_q)
      PH_IDLE: begin
        if (cpu_req && !snp_valid) begin
          if (!cpu_we && hit) begin
            cpu_ready = 1'b1;
            cpu_rdata = la_data;
          end else if (cpu_we && hit && (la_st == LS_DIRTY)) begin
            cpu_ready = 1'b1;
            lw_en     = 1'b1;
            lw_st     = LS_DIRTY;
          end else if (victim_dirty) begin
            phase_d = PH_WB;
          end else begin
            phase_d = after_wb;
          end
        end
      end
      PH_WB: begin
        // re-checked each cycle: a snoop may have taken the Dirty state away
        if (victim_dirty) begin
          bus_req   = 1'b1;
          bus_cmd   = BC_WB;
          bus_addr  = {la_tag, cpu_idx};
          bus_wdata = la_data;
          if (bus_gnt) begin
            lw_en   = 1'b1;
            lw_st   = LS_INV;
            lw_tag  = la_tag;
            lw_data = la_data;
            phase_d = after_wb;
          end
        end else begin
          phase_d = after_wb;
        end
      end
      PH_FILL: begin
        bus_req = 1'b1;
        if (bus_gnt) begin
          cpu_ready = 1'b1;
          cpu_rdata = bus_rdata;
          lw_en     = 1'b1;
          lw_st     = LS_CLEAN;
          lw_data   = bus_rdata;
          phase_d   = PH_IDLE;
        end
      end
      PH_WR: begin
        bus_req = 1'b1;
        bus_cmd = BC_WR;
        if (bus_gnt) begin
          cpu_ready = 1'b1;
          lw_en     = 1'b1;
          lw_st     = LS_DIRTY;
          phase_d   = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end
endmodule

// File: rtl/wo_snoop_cache.sv
module wo_snoop_cache
  import wo_cache_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic [DW-1:0] cpu_rdata,
  output logic          bus_req,
  output logic [1:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_gnt,
  input  logic [DW-1:0] bus_rdata,
  input  logic          snp_valid,
  input  logic          snp_wr,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_inhibit,
  output logic [DW-1:0] snp_data
);
  localparam int TW = AW - IW;

  logic [1:0]    rs_q;
  logic          rst_int_n;
  line_st_e      la_st, sa_st, sw_st, lw_st;
  logic [TW-1:0] la_tag, sa_tag, lw_tag;
  logic [DW-1:0] la_data, sa_data, lw_data;
  logic          sw_en, lw_en;
  bus_cmd_e      cmd_e;

  // reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_int_n = rs_q[1];

  wo_line_store #(.IW(IW), .TW(TW), .DW(DW)) u_store (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .la_idx  (cpu_addr[IW-1:0]),
    .la_st   (la_st),
    .la_tag  (la_tag),
    .la_data (la_data),
    .sa_idx  (snp_addr[IW-1:0]),
    .sa_st   (sa_st),
    .sa_tag  (sa_tag),
    .sa_data (sa_data),
    .sw_en   (sw_en),
    .sw_st   (sw_st),
    .lw_en   (lw_en),
    .lw_st   (lw_st),
    .lw_tag  (lw_tag),
    .lw_data (lw_data)
  );

  wo_snoop_unit #(.TW(TW), .DW(DW)) u_snoop (
    .snp_valid (snp_valid),
    .snp_wr    (snp_wr),
    .snp_tag   (snp_addr[AW-1:IW]),
    .sa_st     (sa_st),
    .sa_tag    (sa_tag),
    .sa_data   (sa_data),
    .inhibit   (snp_inhibit),
    .sdata     (snp_data),
    .sw_en     (sw_en),
    .sw_st     (sw_st)
  );

  wo_ctrl_fsm #(.IW(IW), .TW(TW), .DW(DW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_tag   (cpu_addr[AW-1:IW]),
    .cpu_idx   (cpu_addr[IW-1:0]),
    .cpu_wdata (cpu_wdata),
    .snp_valid (snp_valid),
    .la_st     (la_st),
    .la_tag    (la_tag),
    .la_data   (la_data),
    .bus_gnt   (bus_gnt),
    .bus_rdata (bus_rdata),
    .cpu_ready (cpu_ready),
    .cpu_rdata (cpu_rdata),
    .bus_req   (bus_req),
    .bus_cmd   (cmd_e),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .lw_en     (lw_en),
    .lw_st     (lw_st),
    .lw_tag    (lw_tag),
    .lw_data   (lw_data)
  );

  assign bus_cmd = cmd_e;
endmodule

// File: rtl/wo_snoop_cache_chk.sv
module wo_snoop_cache_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_ready,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic [1:0]    bus_cmd,
  input logic          snp_valid,
  input logic [AW-1:0] snp_addr,
  input logic          snp_inhibit
);
  // R10: a pending request waits for its grant
  a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt && !snp_valid) |=> bus_req);

  // R2: completing without a grant means no bus traffic
  a_r2_ready_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && !bus_gnt) |-> !bus_req);

  // R9: a snoop cycle stalls the local side
  a_r9_snoop_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !cpu_ready);

  // R6: inhibit only answers a snooped transaction
  a_r6_inhibit_in_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    snp_inhibit |-> snp_valid);

  // R6: after supplying, ownership of that word is gone
  a_r6_supply_once: assert property (@(posedge clk) disable iff (!rst_n)
    snp_inhibit |=> !(snp_valid && snp_inhibit && (snp_addr == $past(snp_addr))));

  // R8: a granted writeback is followed by the fill or write
  a_r8_wb_then_access: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && (bus_cmd == 2'd2)) |=> (bus_req && (bus_cmd != 2'd2)));
endmodule

bind wo_snoop_cache wo_snoop_cache_chk #(.AW(AW)) u_chk (.*);

// File: tb/wo_snoop_cache_tb_top.sv
module wo_snoop_cache_tb_top;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int IW = 3;
  localparam int NL = 1 << IW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req, cpu_we;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata;
  logic          cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic          bus_req;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_gnt;
  logic [DW-1:0] bus_rdata;
  logic          snp_valid, snp_wr;
  logic [AW-1:0] snp_addr;
  logic          snp_inhibit;
  logic [DW-1:0] snp_data;

  int checks = 0;
  int errors = 0;
  int hold_gnt = 0;
  int gw = 0;
  int gd = 0;

  // model: 0 invalid, 1 clean, 2 dirty; phase 0 idle, 1 writeback, 2 fill, 3 write
  int m_st [NL];
  int m_tag[NL];
  int m_dat[NL];
  int phase = 0;
  int mem[int];

  always #5 clk = ~clk;

  wo_snoop_cache #(.AW(AW), .DW(DW), .IW(IW)) dut_i (.*);

  function automatic int mem_rd(int a);
    if (mem.exists(a)) return mem[a];
    return ((a * 257) ^ 'h5a00) & 'hffff;
  endfunction

  task automatic chk(string rq, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // grant and read data, driven after the CPU and snoop inputs settle
  always @(posedge clk) begin
    #2;
    if (!rst_n) begin
      bus_gnt = 1'b0;
      gw = 0;
    end else begin
      bus_gnt = bus_req && !snp_valid && (hold_gnt == 0) && (gw >= gd);
      if (bus_gnt) begin
        gw = 0;
        gd = $urandom % 3;
      end else if (bus_req) begin
        gw++;
      end
    end
    bus_rdata = DW'(mem_rd(int'(bus_addr)));
  end

  always @(negedge clk) begin : ref_model
    int idx, tg, sidx, stg, n_phase, lw, lw_st, lw_tag, lw_dat;
    int e_rdy, e_rd, e_req, e_cmd, e_addr, e_wd, e_inh, e_sd;
    bit hit, vd, shit;
    string rq;
    if (!rst_n) begin
      for (int i = 0; i < NL; i++) m_st[i] = 0;
      phase = 0;
    end else begin
      idx  = int'(cpu_addr) % NL;
      tg   = int'(cpu_addr) / NL;
      hit  = (m_st[idx] != 0) && (m_tag[idx] == tg);
      vd   = (m_st[idx] == 2) && !hit;
      sidx = int'(snp_addr) % NL;
      stg  = int'(snp_addr) / NL;
      shit = snp_valid && (m_st[sidx] != 0) && (m_tag[sidx] == stg);
      e_inh = (shit && m_st[sidx] == 2) ? 1 : 0;
      e_sd  = e_inh ? m_dat[sidx] : 0;
      e_rdy = 0; e_rd = 0; e_req = 0; e_cmd = 0;
      e_addr = int'(cpu_addr); e_wd = int'(cpu_wdata);
      n_phase = phase; lw = 0; lw_st = 0; lw_tag = tg; lw_dat = int'(cpu_wdata);
      rq = "R10";
      case (phase)
        0: begin
          rq = "R1";
          if (cpu_req) begin
            if (snp_valid) rq = "R9";
            else if (!cpu_we && hit) begin
              rq = "R2"; e_rdy = 1; e_rd = m_dat[idx];
            end else if (cpu_we && hit && m_st[idx] == 2) begin
              rq = "R5"; e_rdy = 1; lw = 1; lw_st = 2;
            end else if (vd) n_phase = 1;
            else n_phase = cpu_we ? 3 : 2;
          end
        end
        1: begin
          rq = "R8";
          if (vd) begin
            e_req = 1; e_cmd = 2;
            e_addr = m_tag[idx] * NL + idx; e_wd = m_dat[idx];
            if (bus_gnt) begin
              mem[e_addr] = e_wd;
              lw = 1; lw_st = 0; lw_tag = m_tag[idx]; lw_dat = m_dat[idx];
              n_phase = cpu_we ? 3 : 2;
            end
          end else n_phase = cpu_we ? 3 : 2;
        end
        2: begin
          rq = "R3"; e_req = 1;
          if (bus_gnt) begin
            e_rdy = 1; e_rd = mem_rd(int'(cpu_addr));
            lw = 1; lw_st = 1; lw_dat = e_rd; n_phase = 0;
          end
        end
        default: begin
          rq = "R4"; e_req = 1; e_cmd = 1;
          if (bus_gnt) begin
            mem[int'(cpu_addr)] = int'(cpu_wdata);
            e_rdy = 1; lw = 1; lw_st = 2; n_phase = 0;
          end
        end
      endcase
      chk(rq, "cpu_ready", int'(cpu_ready), e_rdy);
      if (e_rdy == 1 && !cpu_we) chk(rq, "cpu_rdata", int'(cpu_rdata), e_rd);
      chk(rq, "bus_req", int'(bus_req), e_req);
      if (e_req == 1) begin
        chk(rq, "bus_cmd", int'(bus_cmd), e_cmd);
        chk(rq, "bus_addr", int'(bus_addr), e_addr);
        if (e_cmd != 0) chk(rq, "bus_wdata", int'(bus_wdata), e_wd);
      end
      chk((shit && e_inh == 0) ? "R7" : "R6", "snp_inhibit", int'(snp_inhibit), e_inh);
      if (e_inh == 1) chk("R6", "snp_data", int'(snp_data), e_sd);
      if (shit) begin
        if (m_st[sidx] == 2) m_st[sidx] = snp_wr ? 0 : 1;
        else if (snp_wr) m_st[sidx] = 0;
      end
      if (lw == 1) begin
        m_st[idx] = lw_st; m_tag[idx] = lw_tag; m_dat[idx] = lw_dat;
      end
      phase = n_phase;
    end
  end

  task automatic cpu_op(bit we, int a, int d);
    @(posedge clk); #1;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = AW'(a); cpu_wdata = DW'(d);
    do @(negedge clk); while (!cpu_ready);
    @(posedge clk); #1;
    cpu_req = 1'b0;
  endtask

  task automatic snoop(bit wr, int a);
    @(posedge clk); #1;
    snp_valid = 1'b1; snp_wr = wr; snp_addr = AW'(a);
    @(posedge clk); #1;
    snp_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    finish_run();
  end

  initial begin
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    snp_valid = 1'b0; snp_wr = 1'b0; snp_addr = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset cpu_ready", int'(cpu_ready), 0);
    chk("R1", "reset bus_req", int'(bus_req), 0);
    chk("R1", "reset snp_inhibit", int'(snp_inhibit), 0);
    // R3 miss then R2 hit
    cpu_op(0, 'h11, 0);
    cpu_op(0, 'h11, 0);
    // R4 write on Clean, R5 silent write on Dirty
    cpu_op(1, 'h11, 'hbeef);
    cpu_op(1, 'h11, 'h1234);
    cpu_op(0, 'h11, 0);
    // R6 supply on snooped read, R7 invalidate Clean
    snoop(0, 'h11);
    snoop(0, 'h11);
    snoop(1, 'h11);
    cpu_op(0, 'h11, 0);
    // R4 write miss, R6 supply on snooped write
    cpu_op(1, 'h22, 'h7777);
    snoop(1, 'h22);
    cpu_op(0, 'h22, 0);
    // R8 dirty eviction
    cpu_op(1, 'h33, 'haaaa);
    cpu_op(0, 'h53, 0);
    cpu_op(0, 'h33, 0);
    // R9 stall in a snoop cycle
    cpu_op(1, 'h44, 'h5555);
    fork
      cpu_op(0, 'h64, 0);
      snoop(0, 'h44);
    join
    // R8 writeback cancelled by a snooped write
    cpu_op(1, 'h45, 'h6666);
    hold_gnt = 1;
    fork
      cpu_op(0, 'h65, 0);
      begin
        repeat (3) @(posedge clk);
        snoop(1, 'h45);
        repeat (2) @(posedge clk);
        #1 hold_gnt = 0;
      end
    join
    // mixed traffic
    for (int k = 0; k < 400; k++) begin
      int a, sa;
      bit we, sw, dosn;
      int dl;
      a    = ($urandom % 4) * NL + ($urandom % 4);
      sa   = ($urandom % 4) * NL + ($urandom % 4);
      we   = 1'($urandom % 2);
      sw   = 1'($urandom % 2);
      dosn = 1'($urandom % 2);
      dl   = $urandom % 4;
      fork
        cpu_op(we, a, $urandom % 65536);
        begin
          repeat (dl) @(posedge clk);
          if (dosn) snoop(sw, sa);
        end
      join
    end
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule